// File: doc/BRIEF.md
# Beat Frequency Aging Counter

This block measures how far a stressed ring oscillator has drifted from a reference ring oscillator. The stressed oscillator output is captured by a flop that runs on the reference oscillator, which folds the small frequency gap into a slow square wave, the beat. After two synchronizing flops, the rising edges of the beat are detected. The block then counts the reference periods between two consecutive rising edges. A larger frequency gap gives a shorter beat and so a smaller count: a 1% gap gives about 100, and a 2% gap about 50.

A measurement starts on a `start` pulse. The first beat edge only arms the counter. The second edge closes the window and raises `meas_done`. If no second edge arrives, the count saturates at the top of its range and the overflow flag is raised. The result is held until the next `start`. It is read out serially on an independent scan clock. The word is taken in parallel while scan enable is low and shifted out most significant bit first while scan enable is high.

Top module: `beat_aging_counter`

## Requirements
- R1: The beat reaches the counter through one sampling flop and two synchronizing flops plus an edge-delay flop. `meas_done` rises on the fourth reference edge after the stressed input makes its closing low-to-high change.
- R2: After `start`, `meas_done` stays 0 while no beat rising edge has been seen. It also stays 0 after the first rising edge, which only arms the count.
- R3: The result equals the number of reference periods between the arming beat edge and the next beat edge. For a stressed waveform synchronous to the reference with period P cycles (2 ≤ P < 65535), the result is exactly P and the overflow flag is 0.
- R4: For free-running oscillators whose frequencies differ by 1%, the result lies in 98..104. For a 2% difference it lies in 49..53.
- R5: With a 16-bit count, if no second edge comes within 65535 reference periods of arming, the measurement ends with `meas_done`=1, `meas_ovf`=1 and the result 65535.
- R6: A `start` pulse in any state aborts the current measurement. On the next reference edge it clears `meas_done`, `meas_ovf` and the result, and waits for a new arming edge.
- R7: Once `meas_done` is 1, further beat edges do not change the result, `meas_done` or `meas_ovf` until the next `start`.
- R8: On a scan clock rising edge with `scan_en` low, the scan register loads an 18-bit word: bit 17 = `meas_done`, bit 16 = `meas_ovf`, bits 15..0 = result.
- R9: On a scan clock rising edge with `scan_en` high, the scan register shifts toward its MSB and `scan_in` enters bit 0. `scan_out` always shows bit 17, so the word leaves MSB first and 18 shifts replace it entirely with the `scan_in` bits.
- R10: With `rst` high over reference and scan clock edges, `meas_done`, `meas_ovf` and `scan_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference ring oscillator, clocks the sampler and counter |
| rst | input | 1 | Synchronous active-high reset, applied in both clock domains |
| stress_osc | input | 1 | Stressed ring oscillator output |
| start | input | 1 | Begins a new measurement, sampled on ref_clk |
| scan_clk | input | 1 | Scan clock for the readout register |
| scan_en | input | 1 | 1 shifts the scan register, 0 loads the result word |
| scan_in | input | 1 | Serial data entering bit 0 of the scan register |
| scan_out | output | 1 | Serial data, MSB of the scan register |
| meas_done | output | 1 | Measurement complete, result valid |
| meas_ovf | output | 1 | No closing beat edge within the count range |

## Verification
The scan register loads a word from the reference domain with no handshake. The assertions on load and shift therefore assume the result is not changing while the scan clock ticks. The stimulus meets this by pulsing the scan clock only during reset or after `meas_done` is seen and before the next `start`. The counting properties assume `start` is a single-cycle pulse driven between reference edges, and every start in the bench is issued that way. Beat waveforms are either built cycle-exactly on the reference clock with random period and duty, or produced by free-running delays whose phase drifts by a tenth of a nanosecond per cycle. This keeps every sampled level change clean.

// File: rtl/bac_pkg.sv
`timescale 1ns/1ps
package bac_pkg;

    // measurement sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2,
        ST_HOLD = 2'd3
    } meas_state_e;

    // flags carried alongside the count in the readout word
    localparam int FLAG_BITS = 2;

    function automatic int scan_width(input int cnt_w);
        return cnt_w + FLAG_BITS;
    endfunction

endpackage

// File: rtl/bac_beat_sampler.sv
`timescale 1ns/1ps
module bac_beat_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst,
    input  logic stress_osc,
    output logic beat_rise
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic               beat_smp;
    logic [CHAIN_W-1:0] chain_q;

    // phase-comparator flop: stressed waveform seen by the reference clock
    always_ff @(posedge ref_clk) begin
        if (rst) beat_smp <= 1'b0;
        else     beat_smp <= stress_osc;
    end

    // synchronizer stages followed by one delay stage for the edge detector
    generate
        for (genvar g = 0; g < CHAIN_W; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge ref_clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= beat_smp;
                end
            end else begin : g_next
                always_ff @(posedge ref_clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign beat_rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

endmodule

// File: rtl/bac_period_counter.sv
`timescale 1ns/1ps
module bac_period_counter
    import bac_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             ref_clk,
    input  logic             rst,
    input  logic             start,
    input  logic             beat_rise,
    output logic [CNT_W-1:0] result,
    output logic             done,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    meas_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge ref_clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            result  <= '0;
            done    <= 1'b0;
            ovf     <= 1'b0;
        end else if (start) begin
            state_q <= ST_ARM;
            cnt_q   <= '0;
            result  <= '0;
            done    <= 1'b0;
            ovf     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ARM: begin
                    // opening edge: the period between edges starts here
                    if (beat_rise) begin
                        state_q <= ST_RUN;
                        cnt_q   <= CNT_ONE;
                    end
                end
                ST_RUN: begin
                    if (beat_rise) begin
                        result  <= cnt_q;
                        done    <= 1'b1;
                        state_q <= ST_HOLD;
                    end else if (cnt_q == CNT_MAX) begin
                        result  <= CNT_MAX;
                        ovf     <= 1'b1;
                        done    <= 1'b1;
                        state_q <= ST_HOLD;
                    end else begin
                        cnt_q <= cnt_q + CNT_ONE;
                    end
                end
                default: begin
                    state_q <= state_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/bac_scan_shifter.sv
`timescale 1ns/1ps
module bac_scan_shifter #(
    parameter int W = 18
) (
    input  logic         scan_clk,
    input  logic         rst,
    input  logic         scan_en,
    input  logic         scan_in,
    input  logic [W-1:0] cap_word,
    output logic [W-1:0] scan_word
);
    always_ff @(posedge scan_clk) begin
        if (rst)          scan_word <= '0;
        else if (scan_en) scan_word <= {scan_word[W-2:0], scan_in};
        else              scan_word <= cap_word;
    end

endmodule

// File: rtl/beat_aging_counter.sv
`timescale 1ns/1ps
module beat_aging_counter
    import bac_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst,
    input  logic stress_osc,
    input  logic start,
    input  logic scan_clk,
    input  logic scan_en,
    input  logic scan_in,
    output logic scan_out,
    output logic meas_done,
    output logic meas_ovf
);
    localparam int SCAN_W = scan_width(CNT_W);

    logic             beat_rise;
    logic [CNT_W-1:0] result_cnt;
    logic [SCAN_W-1:0] cap_word;
    logic [SCAN_W-1:0] scan_word;

    bac_beat_sampler #(.SYNC_STAGES(SYNC_STAGES)) sampler_i (
        .ref_clk    (ref_clk),
        .rst        (rst),
        .stress_osc (stress_osc),
        .beat_rise  (beat_rise)
    );

    bac_period_counter #(.CNT_W(CNT_W)) counter_i (
        .ref_clk   (ref_clk),
        .rst       (rst),
        .start     (start),
        .beat_rise (beat_rise),
        .result    (result_cnt),
        .done      (meas_done),
        .ovf       (meas_ovf)
    );

    assign cap_word = {meas_done, meas_ovf, result_cnt};

    bac_scan_shifter #(.W(SCAN_W)) shift_i (
        .scan_clk  (scan_clk),
        .rst       (rst),
        .scan_en   (scan_en),
        .scan_in   (scan_in),
        .cap_word  (cap_word),
        .scan_word (scan_word)
    );

    assign scan_out = scan_word[SCAN_W-1];

endmodule

// File: rtl/bac_checker.sv
`timescale 1ns/1ps
module bac_checker #(
    parameter int CNT_W = 16
) (
    input logic               ref_clk,
    input logic               scan_clk,
    input logic               rst,
    input logic               start,
    input logic               meas_done,
    input logic               meas_ovf,
    input logic [CNT_W-1:0]   result_cnt,
    input logic               scan_en,
    input logic               scan_in,
    input logic [CNT_W+1:0]   cap_word,
    input logic [CNT_W+1:0]   scan_word
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R3
    closed_window_nonzero_chk: assert property (@(posedge ref_clk) disable iff (rst)
        $rose(meas_done) && !meas_ovf |-> result_cnt != '0);

    // R5
    ovf_saturated_chk: assert property (@(posedge ref_clk) disable iff (rst)
        meas_ovf |-> meas_done && result_cnt == CNT_MAX);

    // R6
    start_clears_chk: assert property (@(posedge ref_clk) disable iff (rst)
        start |=> !meas_done && !meas_ovf && result_cnt == '0);

    // R7
    result_held_chk: assert property (@(posedge ref_clk) disable iff (rst)
        meas_done && !start |=> meas_done && $stable(result_cnt) && $stable(meas_ovf));

    // R8
    scan_capture_chk: assert property (@(posedge scan_clk) disable iff (rst)
        !scan_en |=> scan_word == $past(cap_word));

    // R9
    scan_shift_chk: assert property (@(posedge scan_clk) disable iff (rst)
        scan_en |=> scan_word == {$past(scan_word[CNT_W:0]), $past(scan_in)});

endmodule

bind beat_aging_counter bac_checker #(.CNT_W(CNT_W)) chk_i (
    .ref_clk    (ref_clk),
    .scan_clk   (scan_clk),
    .rst        (rst),
    .start      (start),
    .meas_done  (meas_done),
    .meas_ovf   (meas_ovf),
    .result_cnt (result_cnt),
    .scan_en    (scan_en),
    .scan_in    (scan_in),
    .cap_word   (cap_word),
    .scan_word  (scan_word)
);

// File: tb/beat_aging_counter_tb_top.sv
`timescale 1ns/1ps
module beat_aging_counter_tb_top;
    localparam int CW   = 16;
    localparam int SW   = CW + 2;
    localparam int MAXC = (1 << CW) - 1;

    logic ref_clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic scan_clk = 1'b0;
    logic scan_en = 1'b0;
    logic scan_in = 1'b0;
    logic stress_osc;
    logic scan_out, meas_done, meas_ovf;

    int      mode = 0;          // 0 manual, 1 synchronous pattern, 2 free oscillator
    logic    man_bit = 1'b0;
    logic    pat_bit = 1'b0;
    logic    osc_bit = 1'b0;
    int      pat_per = 10;
    int      pat_hi  = 5;
    int      ph = 0;
    realtime osc_half = 5.05;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    beat_aging_counter dut_i (
        .ref_clk    (ref_clk),
        .rst        (rst),
        .stress_osc (stress_osc),
        .start      (start),
        .scan_clk   (scan_clk),
        .scan_en    (scan_en),
        .scan_in    (scan_in),
        .scan_out   (scan_out),
        .meas_done  (meas_done),
        .meas_ovf   (meas_ovf)
    );

    always #5 ref_clk = ~ref_clk;

    always begin
        #(osc_half) osc_bit = ~osc_bit;
    end

    always @(negedge ref_clk) begin
        if (ph >= pat_per - 1) ph <= 0;
        else                   ph <= ph + 1;
        pat_bit <= (ph < pat_hi);
    end

    assign stress_osc = (mode == 2) ? osc_bit : ((mode == 1) ? pat_bit : man_bit);

    always @(posedge ref_clk) begin
        cyc++;
        if (cyc == 190000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish, act=%0d exp<190000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [SW-1:0] exp_word(input bit o, input int c);
        logic [CW-1:0] cv;
        cv = c[CW-1:0];
        return {1'b1, o, cv};
    endfunction

    task automatic chk(input string req, input longint act, input longint expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, expv);
        end
    endtask

    task automatic chk_range(input string req, input longint act, input longint lo, input longint hi);
        tests++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic pulse_start();
        @(negedge ref_clk);
        start = 1'b1;
        @(negedge ref_clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int lim);
        for (int k = 0; k < lim && !meas_done; k++) @(negedge ref_clk);
    endtask

    task automatic scan_pulse();
        #3 scan_clk = 1'b1;
        #3 scan_clk = 1'b0;
    endtask

    task automatic shift_word(input bit cap, input logic [SW-1:0] din, output logic [SW-1:0] dout);
        if (cap) begin
            scan_en = 1'b0;
            scan_pulse();
        end
        scan_en = 1'b1;
        for (int i = 0; i < SW; i++) begin
            #1 dout[SW-1-i] = scan_out;
            scan_in = din[SW-1-i];
            scan_pulse();
        end
        scan_en = 1'b0;
    endtask

    task automatic set_pattern(input int per, input int hi);
        @(posedge ref_clk);
        #1;
        mode    = 1;
        pat_per = per;
        pat_hi  = hi;
        ph      = 0;
        cycles(2 * per + 8);
    endtask

    task automatic measure_pattern(input int per, input int hi);
        logic [SW-1:0] w;
        set_pattern(per, hi);
        pulse_start();
        wait_done(3 * per + 20);
        chk("R3 done after two edges", meas_done, 1);
        shift_word(1'b1, '0, w);
        chk($sformatf("R3 period %0d high %0d", per, hi), w, exp_word(0, per));
    endtask

    initial begin
        logic [SW-1:0] w;
        logic [SW-1:0] pat;
        logic [SW-1:0] first_w;
        int per, hi;
        void'($urandom(32'd2718));

        // R10 reset state
        cycles(3);
        scan_pulse();
        scan_pulse();
        chk("R10 done in reset", meas_done, 0);
        chk("R10 ovf in reset", meas_ovf, 0);
        chk("R10 scan_out in reset", scan_out, 0);
        @(negedge ref_clk);
        rst = 1'b0;

        // R2 / R1 / R3 directed manual edges
        mode = 0;
        man_bit = 1'b0;
        cycles(6);
        pulse_start();
        cycles(20);
        chk("R2 no edge yet", meas_done, 0);
        man_bit = 1'b1;
        cycles(10);
        chk("R2 first edge only arms", meas_done, 0);
        man_bit = 1'b0;
        cycles(15);
        man_bit = 1'b1;
        cycles(3);
        chk("R1 done not before fourth edge", meas_done, 0);
        cycles(1);
        chk("R1 done on fourth edge", meas_done, 1);
        shift_word(1'b1, '0, w);
        chk("R3 manual gap 25", w, exp_word(0, 25));

        // R3 corner periods
        measure_pattern(2, 1);
        measure_pattern(3, 2);
        measure_pattern(400, 1);

        // R3 random periods and duty
        for (int n = 0; n < 14; n++) begin
            per = 2 + int'($urandom % 399);
            hi  = 1 + int'($urandom % (per - 1));
            measure_pattern(per, hi);
        end

        // R7 result held while beat keeps running
        measure_pattern(40, 13);
        cycles(200);
        chk("R7 done held", meas_done, 1);
        shift_word(1'b1, '0, w);
        chk("R7 result held", w, exp_word(0, 40));

        // R9 serial pass-through of scan_in
        pat = SW'($urandom);
        shift_word(1'b0, pat, w);
        shift_word(1'b0, '0, w);
        chk("R9 scan_in reaches scan_out MSB first", w, pat);

        // R6 restart in the middle of a measurement
        set_pattern(300, 150);
        pulse_start();
        cycles(200);
        pulse_start();
        chk("R6 restart clears done", meas_done, 0);
        wait_done(1000);
        shift_word(1'b1, '0, w);
        chk("R6 restarted result", w, exp_word(0, 300));

        // R4 free-running oscillators, 1% and 2% apart
        mode = 2;
        osc_half = 5.05;
        cycles(300);
        pulse_start();
        wait_done(400);
        shift_word(1'b1, '0, first_w);
        chk("R4 done 1%", first_w[SW-1], 1);
        chk_range("R4 count 1%", first_w[CW-1:0], 98, 104);
        osc_half = 5.10;
        cycles(300);
        pulse_start();
        wait_done(300);
        shift_word(1'b1, '0, w);
        chk("R4 done 2%", w[SW-1], 1);
        chk_range("R4 count 2%", w[CW-1:0], 49, 53);

        // R5 saturation when the closing edge never arrives
        mode = 0;
        man_bit = 1'b0;
        cycles(5);
        pulse_start();
        man_bit = 1'b1;
        cycles(MAXC - 10);
        chk("R5 not finished before limit", meas_done, 0);
        wait_done(100);
        chk("R5 ovf flag", meas_ovf, 1);
        shift_word(1'b1, '0, w);
        chk("R5 saturated word", w, exp_word(1, MAXC));

        // R6 start after overflow clears both flags
        pulse_start();
        chk("R6 done cleared", meas_done, 0);
        chk("R6 ovf cleared", meas_ovf, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule